// File: doc/BRIEF.md
# Register-Built DMA Descriptor Queue

This block sits between a processor's register bus and a DMA engine. Software fills in a descriptor through a small register file. The config base address and the config length fields keep their values from one descriptor to the next. A write to the input/output base address register captures all fields at once and adds the result to a single internal FIFO. The DMA engine takes descriptors from the head of that FIFO through a valid/ready handshake. Each descriptor carries a derived filter address, so the engine never adds it up itself.

A read-only diagnostics word reports three conditions. Bit 0 shows that a descriptor was lost to a full queue, and it stays set until reset. Bit 1 shows that the queue is close to full. Bit 2 shows that the external inference-limit signal is active. While that signal is high, descriptor requests are turned away.

Top module: `dmaq_top`

## Requirements
- R1: After reset, the queue is empty (`dsc_valid` = 0), and all four registers read back 0.
- R2: A write to byte offset 0x8 adds one descriptor {cfg_base, cfg_len, filter_addr, io_base}. The io_base field is the newly written value. Writes to offsets 0x0 and 0x4 add nothing.
- R3: The config base (0x0) and config length (0x4) keep their values after an enqueue, so repeated writes to 0x8 reuse them.
- R4: The filter address equals cfg_base + (cfg_len + 2) * CFG_WORD_BYTES. The field at 0x4 holds the number of 64-bit config words minus 2.
- R5: The low ALIGN_BITS bits of both base addresses are stored as 0. These bits read back as 0 and are delivered as 0.
- R6: A write to 0x8 while the queue is full and the limit is inactive drops that descriptor and leaves the queue contents unchanged. It also sets diagnostics bit 0, which stays at 1 until reset.
- R7: Diagnostics bit 1 reads 1 exactly when the free entries are at or below AF_THRESH. This includes the full case.
- R8: Diagnostics bit 2 follows `limit_hit`. A write to 0x8 while `limit_hit` is high stores nothing and does not set bit 0.
- R9: Descriptors leave oldest first. One descriptor is removed on each clock edge where `dsc_valid` and `dsc_ready` are both high.
- R10: A read returns its data on `reg_rdata` with `reg_rvalid` one cycle after `reg_rd`. Offsets 0x0, 0x4 and 0x8 return their last stored values, and 0xC returns the diagnostics word. Diagnostics bits 31:3 read 0, and writes to 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| limit_hit | input | 1 | Inference limit reached; blocks enqueues |
| dsc_valid | output | 1 | A descriptor is at the queue head |
| dsc_ready | input | 1 | Downstream accepts the head descriptor |
| dsc_cfg_base | output | AW | Config/filter buffer base address |
| dsc_cfg_len | output | LW | Config length field (word count minus 2) |
| dsc_filter_addr | output | AW | Derived filter buffer address |
| dsc_io_base | output | AW | Input/output buffer base address |

## Verification
The bench builds the block with DEPTH = 4 and AF_THRESH = 1. This lets a handful of writes take the queue through the below-threshold, almost-full, full and overflow states, and lets each state be read back from the diagnostics word. ALIGN_BITS = 6 is used with unaligned write data, which exercises the masking of the base addresses. A nonzero length field makes the filter offset differ visibly from the config base.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_IO   = 2'd2,
    SEL_DIAG = 2'd3
  } reg_sel_e;

  localparam int DIAG_OVF   = 0;
  localparam int DIAG_AFULL = 1;
  localparam int DIAG_LIMIT = 2;
endpackage

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [REG_DW-1:0] diag,
  output logic [REG_DW-1:0] rdata,
  output logic              rvalid,
  output logic [AW-1:0]     cfg_base,
  output logic [LW-1:0]     cfg_len,
  output logic              enq_req,
  output logic [AW-1:0]     enq_io
);
  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));

  reg_sel_e          sel;
  logic              hit;
  logic              cfg_en, len_en, io_en;
  logic [AW-1:0]     cfg_base_q, cfg_base_d;
  logic [LW-1:0]     cfg_len_q,  cfg_len_d;
  logic [AW-1:0]     io_base_q,  io_base_d;
  logic [REG_DW-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  // Decode: word-aligned byte offsets only
  always_comb begin
    sel    = reg_sel_e'(addr[3:2]);
    hit    = (addr[1:0] == 2'b00);
    cfg_en = wr && hit && (sel == SEL_CFG);
    len_en = wr && hit && (sel == SEL_LEN);
    io_en  = wr && hit && (sel == SEL_IO);
  end

  // Next-state values
  always_comb begin
    cfg_base_d = wdata[AW-1:0] & ALIGN_MASK;
    cfg_len_d  = wdata[LW-1:0];
    io_base_d  = wdata[AW-1:0] & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_base_q <= '0;
      cfg_len_q  <= '0;
      io_base_q  <= '0;
    end else begin
      if (cfg_en) cfg_base_q <= cfg_base_d;
      if (len_en) cfg_len_q  <= cfg_len_d;
      if (io_en)  io_base_q  <= io_base_d;
    end
  end

  // Read mux, registered on the read strobe
  always_comb begin
    rdata_d = '0;
    if (hit) begin
      unique case (sel)
        SEL_CFG:  rdata_d = REG_DW'(cfg_base_q);
        SEL_LEN:  rdata_d = REG_DW'(cfg_len_q);
        SEL_IO:   rdata_d = REG_DW'(io_base_q);
        SEL_DIAG: rdata_d = diag;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;
  assign cfg_base = cfg_base_q;
  assign cfg_len  = cfg_len_q;
  assign enq_req  = io_en;
  assign enq_io   = io_base_d;

  // R3: config fields persist unless their own offset is written
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en) |=> $stable(cfg_base_q));
  // R10: read data valid exactly one cycle after the strobe
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
endmodule

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int DW        = 112,
  parameter int DEPTH     = 8,
  parameter int AF_THRESH = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic                       nonempty,
  output logic                       full,
  output logic                       almost_full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d, free_w;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop  && (cnt_q != '0);
    wptr_d  = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    rptr_d  = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    cnt_d   = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (!do_push && do_pop) cnt_d = cnt_q - CW'(1);
    free_w  = CW'(DEPTH) - cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_d;
      if (do_pop)  rptr_q <= rptr_d;
      if (do_push || do_pop) cnt_q <= cnt_d;
    end
  end

  // Storage: one enable per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = do_push && (wptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) mem[i] <= din;
    end
  end

  assign dout        = mem[rptr_q];
  assign nonempty    = (cnt_q != '0);
  assign full        = (cnt_q == CW'(DEPTH));
  assign almost_full = (free_w <= CW'(AF_THRESH));
  assign count       = cnt_q;

  // R9: occupancy never exceeds the depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9: a pop with no push lowers occupancy by one
  p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && nonempty) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dmaq_diag.sv
module dmaq_diag
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_req,
  input  logic              limit_hit,
  input  logic              full,
  input  logic              almost_full,
  output logic              push,
  output logic [REG_DW-1:0] diag
);
  logic ovf_q, ovf_set;

  always_comb begin
    push    = enq_req && !limit_hit && !full;
    ovf_set = enq_req && !limit_hit && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
  end

  always_comb begin
    diag             = '0;
    diag[DIAG_OVF]   = ovf_q;
    diag[DIAG_AFULL] = almost_full || full;
    diag[DIAG_LIMIT] = limit_hit;
  end

  // R6: overflow flag is sticky once set
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8: a rejected request never raises the overflow flag
  p_limit_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_q && enq_req && limit_hit) |=> !ovf_q);
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int AW             = 32,
  parameter int LW             = 16,
  parameter int DEPTH          = 8,
  parameter int AF_THRESH      = 1,
  parameter int ALIGN_BITS     = 6,
  parameter int CFG_WORD_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  input  logic          limit_hit,
  output logic          dsc_valid,
  input  logic          dsc_ready,
  output logic [AW-1:0] dsc_cfg_base,
  output logic [LW-1:0] dsc_cfg_len,
  output logic [AW-1:0] dsc_filter_addr,
  output logic [AW-1:0] dsc_io_base
);
  localparam int DW = 3 * AW + LW;
  localparam int SH = $clog2(CFG_WORD_BYTES);
  localparam int CW = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic              rstn_i;
  logic [REG_DW-1:0] diag;
  logic [AW-1:0]     cfg_base, enq_io, filter_addr;
  logic [LW-1:0]     cfg_len;
  logic              enq_req, push, pop;
  logic              full, almost_full, nonempty;
  logic [CW-1:0]     count;
  logic [DW-1:0]     din, dout;

  assign rstn_i = rst_s2;

  dmaq_regs #(.AW(AW), .LW(LW), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk(clk), .rst_n(rstn_i), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .diag(diag), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .enq_req(enq_req), .enq_io(enq_io)
  );

  dmaq_diag u_diag (
    .clk(clk), .rst_n(rstn_i), .enq_req(enq_req), .limit_hit(limit_hit),
    .full(full), .almost_full(almost_full), .push(push), .diag(diag)
  );

  // Filter buffer follows the config buffer
  always_comb begin
    filter_addr = cfg_base + ((AW'(cfg_len) + AW'(2)) << SH);
    din         = {cfg_base, cfg_len, filter_addr, enq_io};
  end

  assign pop = nonempty && dsc_ready;

  dmaq_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_THRESH(AF_THRESH)) u_fifo (
    .clk(clk), .rst_n(rstn_i), .push(push), .din(din), .pop(pop),
    .dout(dout), .nonempty(nonempty), .full(full),
    .almost_full(almost_full), .count(count)
  );

  assign dsc_valid = nonempty;
  assign {dsc_cfg_base, dsc_cfg_len, dsc_filter_addr, dsc_io_base} = dout;

  // R2: an accepted enqueue grows the queue by one
  p_enq_push_r2: assert property (@(posedge clk) disable iff (!rstn_i)
    (enq_req && !limit_hit && !full && !pop) |=> (count == $past(count) + CW'(1)));
  // R6: a drop on a full queue leaves occupancy unchanged
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstn_i)
    (enq_req && full && !pop) |=> (count == $past(count)));
  // R8: a request under the limit stores nothing
  p_limit_reject_r8: assert property (@(posedge clk) disable iff (!rstn_i)
    (enq_req && limit_hit && !pop) |=> (count == $past(count)));
endmodule

// File: tb/sim_dmaq_top.sv
module sim_dmaq_top;
  localparam int AW = 32, LW = 16, DEPTH = 4, AF = 1, AB = 6, CWB = 8;
  localparam int DW = 3 * AW + LW;
  localparam logic [AW-1:0] MASK = ~((AW'(1) << AB) - AW'(1));

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_rd, limit_hit, dsc_ready;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic reg_rvalid, dsc_valid;
  logic [AW-1:0] dsc_cfg_base, dsc_filter_addr, dsc_io_base;
  logic [LW-1:0] dsc_cfg_len;

  always #5 clk = ~clk;

  dmaq_top #(.AW(AW), .LW(LW), .DEPTH(DEPTH), .AF_THRESH(AF),
             .ALIGN_BITS(AB), .CFG_WORD_BYTES(CWB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .limit_hit(limit_hit), .dsc_valid(dsc_valid),
    .dsc_ready(dsc_ready), .dsc_cfg_base(dsc_cfg_base), .dsc_cfg_len(dsc_cfg_len),
    .dsc_filter_addr(dsc_filter_addr), .dsc_io_base(dsc_io_base)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] m_cfg;
  logic [LW-1:0] m_len;
  bit m_ovf;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 4'h0) m_cfg = d & MASK;
    if (a == 4'h4) m_len = d[LW-1:0];
    if (a == 4'h8 && !limit_hit) begin
      if (exp_q.size() == DEPTH) m_ovf = 1'b1;
      else exp_q.push_back({m_cfg, m_len,
                            m_cfg + ((AW'(m_len) + AW'(2)) * AW'(CWB)),
                            d & MASK});
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rvalid === 1'b1, "R10 rvalid", reg_rvalid, 1);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] diag_exp();
    logic [31:0] v = '0;
    v[0] = m_ovf;
    v[1] = (DEPTH - exp_q.size()) <= AF;
    v[2] = limit_hit;
    return v;
  endfunction

  task automatic drain();
    @(posedge clk); #1 dsc_ready = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    #1 dsc_ready = 1'b0;
    @(negedge clk);
    check(dsc_valid === 1'b0, "R9 empty after drain", dsc_valid, 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && dsc_valid === 1'b1 && dsc_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected descriptor", dsc_io_base, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check({dsc_cfg_base, dsc_cfg_len, dsc_filter_addr, dsc_io_base} === e,
              "R2 R4 R9 descriptor",
              {dsc_cfg_base, dsc_cfg_len, dsc_filter_addr, dsc_io_base}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    limit_hit = 0; dsc_ready = 0; m_cfg = 0; m_len = 0; m_ovf = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(dsc_valid === 1'b0, "R1 valid", dsc_valid, 0);
    for (int i = 0; i < 4; i++) begin
      rd(4'(i * 4), r);
      check(r === 32'h0, "R1 reg zero", r, 0);
    end

    // R5 alignment, R10 readback, R2 no enqueue from config writes
    wr(4'h0, 32'h1234_5678);
    wr(4'h4, 32'h0000_0003);
    rd(4'h0, r); check(r === 32'h1234_5640, "R5 cfg base masked", r, 32'h1234_5640);
    rd(4'h4, r); check(r === 32'h3, "R10 len readback", r, 3);
    check(dsc_valid === 1'b0, "R2 no enqueue on 0x0/0x4", dsc_valid, 0);

    // R2 enqueue, R3 reuse of config fields
    wr(4'h8, 32'h0000_1FFF);
    rd(4'h8, r); check(r === 32'h1FC0, "R5 R10 io base", r, 32'h1FC0);
    check(dsc_valid === 1'b1, "R2 enqueue", dsc_valid, 1);
    wr(4'h8, 32'h8000_0000);
    rd(4'h0, r); check(r === 32'h1234_5640, "R3 cfg persists", r, 32'h1234_5640);
    drain();

    // R7 fill levels, R6 overflow
    wr(4'h0, 32'h0010_0000);
    wr(4'h4, 32'h0000_00FE);
    for (int k = 0; k < DEPTH; k++) begin
      wr(4'h8, 32'h0200_0000 + 32'(k) * 32'h40);
      rd(4'hC, r); check(r === diag_exp(), "R7 almost full", r, diag_exp());
    end
    wr(4'h8, 32'h0BAD_0000);
    rd(4'hC, r); check(r === 32'h3, "R6 overflow flag", r, 3);
    drain();
    rd(4'hC, r); check(r === 32'h1, "R6 sticky after drain", r, 1);

    // R10 write to diagnostics ignored
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); check(r === 32'h1, "R10 diag write ignored", r, 1);

    // R8 limit rejects
    @(negedge clk); limit_hit = 1'b1;
    wr(4'h8, 32'h0300_0000);
    rd(4'hC, r); check(r === 32'h5, "R8 limit bit", r, 5);
    check(dsc_valid === 1'b0, "R8 nothing stored", dsc_valid, 0);
    @(negedge clk); limit_hit = 1'b0;
    wr(4'h8, 32'h0400_0000);
    check(dsc_valid === 1'b1, "R8 enqueue after limit", dsc_valid, 1);
    drain();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule